// File: doc/BRIEF.md
# Byte-Wide Flash Programming Port

This block models the parallel programming port of a small on-chip code store. A programmer drives an address, a data byte, a three-bit operation code, a program-enable level and an active-low program strobe. A falling edge on the strobe starts a byte write or a lock-bit write. The write then times itself with an internal counter, and no further strobes are needed. While a byte write is in flight, a verify read of that byte returns its complement. The port uses this as a completion poll. Once the write finishes, the true value comes back.

A location that no longer holds FFh cannot be overwritten. Only a whole-array erase restores it. The erase is triggered by holding the strobe low for a parameterised interval. The erase clears the lock bits, then sweeps every location back to FFh, one per cycle. Reset runs the same sweep. Either lock bit, once programmed, hides the array from verify reads. A separate signature operation returns three fixed identification bytes. The read data output is registered, and a busy output reports any timed operation.

Top module: `flash_prog_port`

## Requirements
- R1: From reset the port is busy for exactly DEPTH cycles, counted from the first cycle with reset low, while it sweeps the array. Afterwards every location verifies as FFh, both lock bits are clear, and the output reads FFh while reset is held.
- R2: With enable high and operation code 1, a falling strobe edge starts a byte write of the data to the address. Busy is high for exactly WR_CYC cycles, starting with the cycle after the edge. A blank location then verifies as the written byte.
- R3: A strobe edge is ignored while busy, and is also ignored while enable is low. In either case the array is unchanged and no busy cycle starts.
- R4: While a byte write is in flight, a verify read (code 2) of the address being written returns the bitwise complement of the byte being written. A verify read of any other address returns FFh.
- R5: A byte write to a location not holding FFh runs its full timed cycle and leaves the stored byte unchanged.
- R6: Code 3 programs the first lock bit and code 4 programs the second, each with the same timed strobe procedure as a byte write. With either lock bit set, verify reads return FFh.
- R7: With enable high and code 5, holding the strobe low for ERASE_CYC consecutive cycles starts an erase on the last of them. The erase clears both lock bits, is busy for DEPTH cycles and leaves every byte at FFh. A shorter hold does nothing, and one low interval erases at most once.
- R8: A signature read (code 6) returns 1Eh at address 30h and 51h at 31h. At 32h it returns FFh when HV_VARIANT is 1 and 05h otherwise. Any other address returns FFh. Lock bits do not affect signature reads.
- R9: The read output is registered. It is valid two cycles after the address and code have been held stable. Codes 0, 1, 3, 4, 5 and 7 read as FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Operation code (0 none, 1 write, 2 verify, 3 lock 1, 4 lock 2, 5 erase, 6 signature) |
| prog_en | input | 1 | Program-enable level |
| prog_n | input | 1 | Active-low program strobe |
| addr | input | AW | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Registered read data |
| busy | output | 1 | High while a timed write, lock write or erase runs |

## Verification
The assertions assume the programmer holds the address and operation code steady for at least two cycles before it relies on a read. They also assume WR_CYC and ERASE_CYC are at least two, so the old byte is fetched before a write commits. The stimulus changes inputs only on falling clock edges and holds each read setup for three cycles. It waits for busy to fall before it issues the next operation, except in the polling and busy-strobe cases, which deliberately act during a write.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] BLANK    = 8'hFF;
  localparam logic [DW-1:0] SIG_MFR  = 8'h1E;
  localparam logic [DW-1:0] SIG_DEV  = 8'h51;
  localparam logic [DW-1:0] SIG_HV   = 8'hFF;
  localparam logic [DW-1:0] SIG_LV   = 8'h05;

  typedef enum logic [2:0] {
    M_NONE   = 3'd0,
    M_WRITE  = 3'd1,
    M_VERIFY = 3'd2,
    M_LOCK1  = 3'd3,
    M_LOCK2  = 3'd4,
    M_ERASE  = 3'd5,
    M_SIG    = 3'd6,
    M_RSVD   = 3'd7
  } fp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_LOCK,
    ST_ERASE
  } fp_state_e;
endpackage

// File: rtl/fp_array.sv
module fp_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/fp_seq.sv
module fp_seq
  import fp_pkg::*;
#(
  parameter int AW        = 8,
  parameter int WR_CYC    = 50,
  parameter int ERASE_CYC = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  fp_mode_e      mode,
  input  logic          prog_en,
  input  logic          prog_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_q,
  output logic          busy,
  output logic          polling,
  output logic          lock_any,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int CW = $clog2(WR_CYC + 1);
  localparam int HW = $clog2(ERASE_CYC + 1);

  fp_state_e     st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold_cnt;
  logic          erase_fired;
  logic [AW-1:0] sweep;
  logic [1:0]    lock_prog;
  logic          lock_sel;
  logic          prog_q;
  logic          fall;
  logic          erase_hold;
  logic          hold_full;

  assign fall       = prog_q & ~prog_n;
  assign erase_hold = prog_en && (mode == M_ERASE) && !prog_n;
  assign hold_full  = (hold_cnt == HW'(ERASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_ERASE;
      sweep       <= '0;
      lock_prog   <= '0;
      lock_sel    <= 1'b0;
      prog_q      <= 1'b1;
      hold_cnt    <= '0;
      erase_fired <= 1'b0;
      cnt         <= '0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      prog_q <= prog_n;
      if (!erase_hold) begin
        hold_cnt    <= '0;
        erase_fired <= 1'b0;
      end else if (!hold_full) begin
        hold_cnt <= hold_cnt + 1'b1;
      end

      case (st)
        ST_IDLE: begin
          if (erase_hold && hold_full && !erase_fired) begin
            st          <= ST_ERASE;
            sweep       <= '0;
            lock_prog   <= '0;
            erase_fired <= 1'b1;
          end else if (fall && prog_en && mode == M_WRITE) begin
            st      <= ST_WRITE;
            wr_addr <= addr;
            wr_data <= din;
            cnt     <= CW'(WR_CYC - 1);
          end else if (fall && prog_en && (mode == M_LOCK1 || mode == M_LOCK2)) begin
            st       <= ST_LOCK;
            lock_sel <= (mode == M_LOCK2);
            cnt      <= CW'(WR_CYC - 1);
          end
        end
        ST_WRITE: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        ST_LOCK: begin
          if (cnt == '0) begin
            lock_prog[lock_sel] <= 1'b1;
            st                  <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          sweep <= sweep + 1'b1;
          if (&sweep) st <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    mem_addr  = addr;
    mem_wdata = wr_data;
    mem_we    = 1'b0;
    if (st == ST_WRITE) begin
      mem_addr = wr_addr;
      mem_we   = (cnt == '0) && (rd_q == BLANK);
    end else if (st == ST_ERASE) begin
      mem_addr  = sweep;
      mem_wdata = BLANK;
      mem_we    = 1'b1;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign polling  = (st == ST_WRITE);
  assign lock_any = |lock_prog;

  // R2
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WRITE && cnt != '0) |=> (st == ST_WRITE && $stable(wr_addr) && $stable(wr_data)));
  // R7
  erase_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE) |-> (lock_prog == 2'b00));
  // R6
  lock_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((lock_prog & ~$past(lock_prog)) != 2'b00) |-> ($past(st) == ST_LOCK));
  // R1
  sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE && &sweep) |=> (st == ST_IDLE));
endmodule

// File: rtl/flash_prog_port.sv
module flash_prog_port
  import fp_pkg::*;
#(
  parameter int AW         = 8,
  parameter int WR_CYC     = 50,
  parameter int ERASE_CYC  = 500000,
  parameter bit HV_VARIANT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode_sel,
  input  logic          prog_en,
  input  logic          prog_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          busy
);
  localparam logic [DW-1:0] SIG3 = HV_VARIANT ? SIG_HV : SIG_LV;
  localparam logic [AW-1:0] A_MFR = AW'(8'h30);
  localparam logic [AW-1:0] A_DEV = AW'(8'h31);
  localparam logic [AW-1:0] A_PGM = AW'(8'h32);

  fp_mode_e      mode;
  logic [DW-1:0] rd_q;
  logic          polling;
  logic          lock_any;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  assign mode = fp_mode_e'(mode_sel);

  fp_seq #(.AW(AW), .WR_CYC(WR_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk(clk), .rst(rst), .mode(mode), .prog_en(prog_en), .prog_n(prog_n),
    .addr(addr), .din(din), .rd_q(rd_q), .busy(busy), .polling(polling),
    .lock_any(lock_any), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  fp_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= BLANK;
    end else begin
      case (mode)
        M_SIG: begin
          if      (addr == A_MFR) dout <= SIG_MFR;
          else if (addr == A_DEV) dout <= SIG_DEV;
          else if (addr == A_PGM) dout <= SIG3;
          else                    dout <= BLANK;
        end
        M_VERIFY: begin
          if (polling)       dout <= (addr == wr_addr) ? ~wr_data : BLANK;
          else if (busy)     dout <= BLANK;
          else if (lock_any) dout <= BLANK;
          else               dout <= rd_q;
        end
        default: dout <= BLANK;
      endcase
    end
  end

  // R8
  sig_mfr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode_sel == 3'd6 && addr == A_MFR) |-> (dout == 8'h1E));
  // R6
  verify_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode_sel == 3'd2 && !busy && lock_any) |-> (dout == 8'hFF));
  // R4
  poll_cpl_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode_sel == 3'd2 && polling && addr == wr_addr) |-> (dout == ~$past(wr_data)));
endmodule

// File: tb/flash_prog_port_tb.sv
module flash_prog_port_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int WRC = 20;
  localparam int ERC = 40;
  localparam logic [2:0] C_NONE = 3'd0, C_WR = 3'd1, C_VER = 3'd2, C_LK1 = 3'd3,
                         C_LK2 = 3'd4, C_ERS = 3'd5, C_SIG = 3'd6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic [2:0]    mode_sel = C_NONE;
  logic          prog_en = 1'b0;
  logic          prog_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          busy;

  flash_prog_port #(.AW(AW), .WR_CYC(WRC), .ERASE_CYC(ERC), .HV_VARIANT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .prog_en(prog_en), .prog_n(prog_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];
  event  smp_ev;
  int total = 0;
  int bad = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with dout
  initial forever begin
    @(smp_ev);
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      chk(it.tag, int'(dout), int'(it.exp));
    end
  end

  task automatic rd(logic [2:0] m, logic [AW-1:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    mode_sel = m; addr = a;
    repeat (3) @(negedge clk);
    sbq.push_back('{e, tag});
    -> smp_ev;
    #1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // full timed op, returns number of busy cycles
  task automatic prog_op(logic [2:0] m, logic [AW-1:0] a, logic [7:0] d, output int n);
    @(negedge clk);
    mode_sel = m; addr = a; din = d; prog_en = 1'b1;
    @(negedge clk);
    prog_n = 1'b0;
    n = 0;
    @(negedge clk);
    while (busy && n < 100000) begin n++; @(negedge clk); end
    prog_n = 1'b1;
    mode_sel = C_NONE;
  endtask

  task automatic start_write(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    mode_sel = C_WR; addr = a; din = d; prog_en = 1'b1;
    @(negedge clk);
    prog_n = 1'b0;
    @(negedge clk);
    prog_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n, nl, nb;
    // R1 reset state and sweep length
    repeat (3) @(negedge clk);
    chk("R1 dout in reset", int'(dout), 8'hFF);
    rst = 1'b0;
    nb = 0;
    while (busy && nb < 100000) begin nb++; @(negedge clk); end
    chk("R1 reset sweep cycles", nb, DEPTH);
    rd(C_VER, 8'h00, 8'hFF, "R1 blank addr 0");
    rd(C_VER, 8'hFF, 8'hFF, "R1 blank top addr");

    // R8 signatures
    rd(C_SIG, 8'h30, 8'h1E, "R8 sig 30h");
    rd(C_SIG, 8'h31, 8'h51, "R8 sig 31h");
    rd(C_SIG, 8'h32, 8'hFF, "R8 sig 32h hv");
    rd(C_SIG, 8'h33, 8'hFF, "R8 sig other");

    // R2 write and timing
    prog_op(C_WR, 8'd10, 8'h5A, n);
    chk("R2 write busy cycles", n, WRC);
    rd(C_VER, 8'd10, 8'h5A, "R2 verify 5A");
    prog_op(C_WR, 8'd200, 8'h00, n);
    rd(C_VER, 8'd200, 8'h00, "R2 verify 00");

    // R5 non-blank rewrite rejected
    prog_op(C_WR, 8'd10, 8'h0F, n);
    chk("R5 rejected write busy cycles", n, WRC);
    rd(C_VER, 8'd10, 8'h5A, "R5 byte unchanged");

    // R4 data polling
    start_write(8'd11, 8'hC3);
    rd(C_VER, 8'd11, 8'h3C, "R4 poll complement");
    rd(C_VER, 8'd12, 8'hFF, "R4 other addr in write");
    chk("R4 still busy", int'(busy), 1);
    wait_idle();
    rd(C_VER, 8'd11, 8'hC3, "R4 true data after");

    // R3 enable low ignored
    @(negedge clk);
    mode_sel = C_WR; addr = 8'd40; din = 8'h44; prog_en = 1'b0;
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); chk("R3 no busy with enable low", int'(busy), 0);
    @(negedge clk); prog_n = 1'b1; chk("R3 no busy later", int'(busy), 0);
    rd(C_VER, 8'd40, 8'hFF, "R3 enable-low write ignored");

    // R3 strobe while busy ignored
    start_write(8'd20, 8'h11);
    @(negedge clk); addr = 8'd21; din = 8'h22;
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    wait_idle();
    mode_sel = C_NONE;
    @(negedge clk);
    chk("R3 no second busy", int'(busy), 0);
    rd(C_VER, 8'd21, 8'hFF, "R3 busy strobe ignored");
    rd(C_VER, 8'd20, 8'h11, "R3 first write kept");

    // R9 non-read code reads FFh
    rd(C_NONE, 8'd20, 8'hFF, "R9 idle code");
    rd(3'd7, 8'd20, 8'hFF, "R9 reserved code");

    // R7 short hold does nothing
    @(negedge clk);
    mode_sel = C_ERS; addr = '0; prog_en = 1'b1;
    @(negedge clk); prog_n = 1'b0;
    repeat (ERC - 2) @(negedge clk);
    chk("R7 short hold no busy", int'(busy), 0);
    prog_n = 1'b1;
    @(negedge clk);
    chk("R7 short hold after release", int'(busy), 0);
    rd(C_VER, 8'd10, 8'h5A, "R7 short hold keeps data");

    // R6 lock bit 1
    prog_op(C_LK1, 8'd0, 8'h00, n);
    chk("R6 lock busy cycles", n, WRC);
    rd(C_VER, 8'd10, 8'hFF, "R6 lock1 hides data");
    rd(C_SIG, 8'h31, 8'h51, "R8 sig under lock");

    // R7 full erase
    @(negedge clk);
    mode_sel = C_ERS; addr = '0; prog_en = 1'b1;
    @(negedge clk); prog_n = 1'b0;
    nl = 0;
    @(negedge clk);
    while (!busy && nl < 100000) begin nl++; @(negedge clk); end
    chk("R7 hold cycles before erase", nl, ERC - 1);
    nb = 0;
    while (busy && nb < 100000) begin nb++; @(negedge clk); end
    chk("R7 erase busy cycles", nb, DEPTH);
    repeat (ERC + 2) @(negedge clk);
    chk("R7 single erase per hold", int'(busy), 0);
    prog_n = 1'b1;
    mode_sel = C_NONE;
    rd(C_VER, 8'd10, 8'hFF, "R7 erased byte");
    prog_op(C_WR, 8'd10, 8'h77, n);
    rd(C_VER, 8'd10, 8'h77, "R7 locks cleared by erase");
    rd(C_VER, 8'd200, 8'hFF, "R7 erased 00 byte");

    // R6 lock bit 2
    prog_op(C_LK2, 8'd0, 8'h00, n);
    rd(C_VER, 8'd10, 8'hFF, "R6 lock2 hides data");

    finish_run();
  end
endmodule